// File: doc/BRIEF.md
# Inverted AMI Frame Transmitter

This block turns a 46-bit frame payload into a stream of line symbols for a 48-bit frame sent at the 192 kb/s line rate. One symbol comes out for every bit-rate strobe, so a full frame takes 48 strobes and frames repeat at 4 kHz. The line uses inverted alternate mark inversion. A binary one is sent as no pulse. A binary zero is sent as a pulse, and successive pulses normally alternate in polarity.

Each frame opens with a two-symbol header: a positive pulse and then a negative balance pulse. The first data pulse after the header is forced negative, the same polarity as the header's balance pulse. This repeated polarity is the code violation a receiver locks onto. Balance bits make the pulse count of each group even. In the network-side direction, three reserved positions carry echo bits taken from the `echo_bit` input. In that direction the frame ends with a single balance bit that covers the whole frame body.

The payload word and the direction select are captured together on the strobe that emits the first header symbol. The source can therefore prepare the next frame while the current one is still being sent.

Top module: `inv_ami_framer`

## Requirements
- R1: While `rst_n` is low at a clock edge, `line_sym` becomes 2'b00. The first strobe after reset emits frame position 0.
- R2: `line_sym` updates only on the clock edge where `bit_stb` is high, and it shows the symbol for that strobe's position from the next cycle on. Without a strobe it holds its value.
- R3: Position 0 is always a positive pulse (2'b01). Position 1 is always a negative pulse (2'b10).
- R4: Symbol codes are 2'b00 for no pulse, 2'b01 for a positive pulse and 2'b10 for a negative pulse. 2'b11 never appears. A body bit of one gives 2'b00 and a body bit of zero gives a pulse.
- R5: In positions 2 to 47, the first pulse after position 1 is negative. Every later pulse in the frame has the opposite polarity of the pulse before it.
- R6: `payload` and `nt_dir` are sampled only on the strobe for position 0. A data position p carries `payload[p-2]`. Changes to these inputs later in the frame have no effect.
- R7: With `nt_dir`=1, positions 12, 24 and 36 carry the value of `echo_bit` sampled on that position's strobe. The payload bits mapped there are ignored. With `nt_dir`=0, `echo_bit` has no effect.
- R8: With `nt_dir`=1, position 47 is a balance bit. It is a zero (pulse) when positions 2 to 46 held an odd number of pulses, and a one otherwise.
- R9: With `nt_dir`=0, positions 11, 23, 35 and 47 are balance bits. Each one closes a group: 2–10, 12–22, 24–34 and 36–46 in turn. Each balance bit makes the pulse count of its group, counting itself, even.
- R10: After position 47 the next strobe emits position 0 of a new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_stb | input | 1 | One-cycle strobe at the line bit rate |
| payload | input | 46 | Frame body, sampled at position 0 |
| nt_dir | input | 1 | 1 selects the network-side frame layout, 0 the terminal-side layout |
| echo_bit | input | 1 | Echo value used at the echo positions |
| line_sym | output | 2 | Line symbol: 00 none, 01 positive, 10 negative |

## Verification
The bench compares every symbol of whole frames against a model built from the requirements. The frames cover all-ones, all-zeros, alternating and irregular payloads in both directions. It goes after the forced same-polarity pulse after the header: a design that simply alternated would flip the first data pulse to positive and every pulse after it. It also targets balance bits on groups with odd and even pulse counts; a wrong parity window would send the wrong symbol at positions 11 to 47. After each capture strobe the bench scrambles the payload, the direction and the echo input, so a design that samples them live would corrupt the frame. A reset in mid-frame, and the symbol held across idle cycles, catch a counter that fails to restart at position 0 and an output that moves without a strobe.

// File: rtl/inv_ami_pkg.sv
// Shared types for the inverted AMI frame transmitter.
package inv_ami_pkg;

    // Line symbol codes driven on the output.
    typedef enum logic [1:0] {
        SYM_NONE = 2'b00,
        SYM_POS  = 2'b01,
        SYM_NEG  = 2'b10
    } sym_t;

    // Role of one bit position within a frame.
    typedef enum logic [2:0] {
        SLOT_MARK = 3'd0,   // header positive pulse
        SLOT_HBAL = 3'd1,   // header negative balance pulse
        SLOT_DATA = 3'd2,   // payload bit
        SLOT_ECHO = 3'd3,   // echo bit, network-side only
        SLOT_BAL  = 3'd4    // group balance bit
    } slot_t;

endpackage

// File: rtl/ami_pos_counter.sv
// Frame position counter.
// Counts strobes from 0 to FRAME_LEN-1 and then wraps to 0.
// Assumes the strobe is a single-cycle pulse.
module ami_pos_counter #(
    parameter  int FRAME_LEN = 48,
    localparam int POS_W     = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [POS_W-1:0] pos
);

    localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_LEN - 1);

    // Advance the position on each strobe and wrap at the frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (adv) begin
            if (pos == LAST) begin
                pos <= '0;
            end else begin
                pos <= pos + POS_W'(1);
            end
        end
    end

endmodule

// File: rtl/ami_slot_map.sv
// Position classifier.
// Maps the frame position and the direction to a slot role.
// Constant masks for each layout are built by a generate loop over
// every position the counter can reach.
// Assumes the header is two positions long and that GROUP_LEN divides
// the frame body into equal groups.
module ami_slot_map
    import inv_ami_pkg::*;
#(
    parameter  int FRAME_LEN = 48,
    parameter  int GROUP_LEN = 12,
    parameter  int HDR_LEN   = 2,
    localparam int POS_W     = $clog2(FRAME_LEN),
    localparam int SPAN      = 2 ** POS_W
) (
    input  logic [POS_W-1:0] pos,
    input  logic             nt_dir,
    output slot_t            slot
);

    logic [SPAN-1:0] echo_m;
    logic [SPAN-1:0] bal_te_m;
    logic [SPAN-1:0] bal_nt_m;

    for (genvar i = 0; i < SPAN; i++) begin : g_mask
        localparam bit IS_ECHO = (i >= GROUP_LEN) && (i < FRAME_LEN - 1) &&
                                 ((i % GROUP_LEN) == 0);
        localparam bit IS_BTE  = (i >= HDR_LEN) && (i < FRAME_LEN) &&
                                 ((i % GROUP_LEN) == (GROUP_LEN - 1));
        localparam bit IS_BNT  = (i == FRAME_LEN - 1);
        assign echo_m[i]   = IS_ECHO;
        assign bal_te_m[i] = IS_BTE;
        assign bal_nt_m[i] = IS_BNT;
    end

    // Pick the slot role from header, direction and the masks.
    always_comb begin
        if (pos == '0) begin
            slot = SLOT_MARK;
        end else if (pos == POS_W'(HDR_LEN - 1)) begin
            slot = SLOT_HBAL;
        end else if (nt_dir) begin
            if (echo_m[pos]) begin
                slot = SLOT_ECHO;
            end else if (bal_nt_m[pos]) begin
                slot = SLOT_BAL;
            end else begin
                slot = SLOT_DATA;
            end
        end else begin
            slot = bal_te_m[pos] ? SLOT_BAL : SLOT_DATA;
        end
    end

endmodule

// File: rtl/ami_bit_source.sv
// Binary bit source.
// Captures payload and direction at position 0 and selects the binary
// value for the current slot. It also keeps the running pulse parity
// of the open balance group.
// Assumes the strobe is a single-cycle pulse and that slot follows pos.
module ami_bit_source
    import inv_ami_pkg::*;
#(
    parameter  int FRAME_LEN = 48,
    parameter  int HDR_LEN   = 2,
    localparam int PAY_W     = FRAME_LEN - HDR_LEN,
    localparam int POS_W     = $clog2(FRAME_LEN),
    localparam int SPAN      = 2 ** POS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [POS_W-1:0] pos,
    input  slot_t            slot,
    input  logic [PAY_W-1:0] payload,
    input  logic             nt_dir,
    input  logic             echo_bit,
    output logic             dir_q,
    output logic             bit_val
);

    logic [PAY_W-1:0] pay_q;
    logic             par_q;
    logic [SPAN-1:0]  pay_ext;
    logic [POS_W-1:0] idx;

    assign pay_ext = {{(SPAN - PAY_W){1'b0}}, pay_q};
    assign idx     = pos - POS_W'(HDR_LEN);

    // Capture the frame's payload and direction on the position-0 strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pay_q <= '1;
            dir_q <= 1'b0;
        end else if (adv && (pos == '0)) begin
            pay_q <= payload;
            dir_q <= nt_dir;
        end
    end

    // Select the binary value sent at the current slot.
    always_comb begin
        unique case (slot)
            SLOT_MARK, SLOT_HBAL: bit_val = 1'b0;
            SLOT_DATA:            bit_val = pay_ext[idx];
            SLOT_ECHO:            bit_val = echo_bit;
            SLOT_BAL:             bit_val = ~par_q;
            default:              bit_val = 1'b1;
        endcase
    end

    // Track pulse parity of the open group; restart at header and balance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_q <= 1'b0;
        end else if (adv) begin
            unique case (slot)
                SLOT_DATA, SLOT_ECHO: if (!bit_val) par_q <= ~par_q;
                default:              par_q <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/ami_line_enc.sv
// Inverted AMI line encoder.
// Turns the binary bit of each slot into a registered line symbol.
// Header slots get fixed polarities. After the header balance pulse the
// next pulse repeats its polarity, and pulses alternate from there on.
// Assumes the strobe is a single-cycle pulse.
module ami_line_enc
    import inv_ami_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  adv,
    input  slot_t slot,
    input  logic  bit_val,
    output sym_t  sym
);

    logic neg_next_q;

    // Emit one symbol per strobe and update the next pulse polarity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym        <= SYM_NONE;
            neg_next_q <= 1'b0;
        end else if (adv) begin
            unique case (slot)
                SLOT_MARK: begin
                    sym <= SYM_POS;
                end
                SLOT_HBAL: begin
                    sym        <= SYM_NEG;
                    neg_next_q <= 1'b1;
                end
                default: begin
                    if (bit_val) begin
                        sym <= SYM_NONE;
                    end else begin
                        sym        <= neg_next_q ? SYM_NEG : SYM_POS;
                        neg_next_q <= ~neg_next_q;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/inv_ami_framer.sv
// Inverted AMI frame transmitter, top level.
// Emits one line symbol per bit strobe for a FRAME_LEN-bit frame. The
// frame has a two-symbol header, a payload body, echo slots when
// nt_dir=1, and group balance bits.
// Assumes bit_stb is a single-cycle pulse.
module inv_ami_framer
    import inv_ami_pkg::*;
#(
    parameter  int FRAME_LEN = 48,
    parameter  int GROUP_LEN = 12,
    localparam int HDR_LEN   = 2,
    localparam int PAY_W     = FRAME_LEN - HDR_LEN,
    localparam int POS_W     = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_stb,
    input  logic [PAY_W-1:0] payload,
    input  logic             nt_dir,
    input  logic             echo_bit,
    output logic [1:0]       line_sym
);

    logic [POS_W-1:0] pos;
    logic             dir_q;
    logic             bit_val;
    slot_t            slot;
    sym_t             sym;

    ami_pos_counter #(.FRAME_LEN(FRAME_LEN)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (bit_stb),
        .pos   (pos)
    );

    ami_slot_map #(
        .FRAME_LEN (FRAME_LEN),
        .GROUP_LEN (GROUP_LEN),
        .HDR_LEN   (HDR_LEN)
    ) u_map (
        .pos    (pos),
        .nt_dir (dir_q),
        .slot   (slot)
    );

    ami_bit_source #(
        .FRAME_LEN (FRAME_LEN),
        .HDR_LEN   (HDR_LEN)
    ) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (bit_stb),
        .pos      (pos),
        .slot     (slot),
        .payload  (payload),
        .nt_dir   (nt_dir),
        .echo_bit (echo_bit),
        .dir_q    (dir_q),
        .bit_val  (bit_val)
    );

    ami_line_enc u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (bit_stb),
        .slot    (slot),
        .bit_val (bit_val),
        .sym     (sym)
    );

    assign line_sym = sym;

endmodule

// File: rtl/inv_ami_framer_chk.sv
// Property checker for the inverted AMI frame transmitter.
// It is bound into the top and watches the strobe, the frame position
// and the line symbol.
module inv_ami_framer_chk #(
    parameter  int FRAME_LEN = 48,
    localparam int POS_W     = $clog2(FRAME_LEN)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             strobe,
    input logic [POS_W-1:0] pos,
    input logic [1:0]       sym
);

    logic             stb_d;
    logic [POS_W-1:0] pos_d;
    logic [1:0]       last_q;
    logic             first_q;

    // Remember the strobe and the position of the symbol now on the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_d <= 1'b0;
            pos_d <= '0;
        end else begin
            stb_d <= strobe;
            pos_d <= pos;
        end
    end

    // Track the last pulse polarity and whether the forced repeat is due.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q  <= 2'b00;
            first_q <= 1'b0;
        end else if (stb_d && (sym != 2'b00)) begin
            last_q <= sym;
            if (pos_d == POS_W'(1)) begin
                first_q <= 1'b1;
            end else if (pos_d >= POS_W'(2)) begin
                first_q <= 1'b0;
            end
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (sym == 2'b00) && (pos == '0));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(sym));

    p_mark_pos_r3: assert property (@(posedge clk) disable iff (!rst_n)
        strobe && (pos == '0) |=> (sym == 2'b01));

    p_mark_neg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        strobe && (pos == POS_W'(1)) |=> (sym == 2'b10));

    p_legal_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sym != 2'b11);

    p_alt_polarity_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stb_d && (pos_d >= POS_W'(2)) && (sym != 2'b00) |->
            (first_q ? (sym == last_q) : (sym != last_q)));

    p_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        strobe && (pos == POS_W'(FRAME_LEN - 1)) |=> (pos == '0));

endmodule

bind inv_ami_framer inv_ami_framer_chk #(.FRAME_LEN(FRAME_LEN)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (bit_stb),
    .pos    (pos),
    .sym    (line_sym)
);

// File: tb/test_inv_ami_framer.sv
module test_inv_ami_framer;

    localparam int CLK_PERIOD = 10;
    localparam int FLEN       = 48;
    localparam int NVEC       = 6;

    // Vector layout: {nt_dir, echo[2:0], payload[45:0]}
    localparam logic [49:0] VEC [NVEC] = '{
        {1'b0, 3'b000, 46'h3FFF_FFFF_FFFF},
        {1'b0, 3'b111, 46'h0000_0000_0000},
        {1'b0, 3'b010, 46'h2AAA_AAAA_AAAA},
        {1'b1, 3'b101, 46'h1234_5678_9ABC},
        {1'b1, 3'b000, 46'h0F0F_3C3C_0001},
        {1'b1, 3'b011, 46'h3FFF_FFFF_FFFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_stb = 1'b0;
    logic [45:0] payload = '0;
    logic        nt_dir = 1'b0;
    logic        echo_bit = 1'b0;
    logic [1:0]  line_sym;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [1:0] exp_frame [FLEN];

    inv_ami_framer i_inv_ami_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_stb  (bit_stb),
        .payload  (payload),
        .nt_dir   (nt_dir),
        .echo_bit (echo_bit),
        .line_sym (line_sym)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: line_sym=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string tag_of(input logic dir, input int p);
        if (p < 2) return "R3";
        if (dir && (p == 12 || p == 24 || p == 36)) return "R7";
        if (dir && p == 47) return "R8";
        if (!dir && (p % 12 == 11)) return "R9";
        return "R4 R5 R6";
    endfunction

    // Expected frame, built from the requirements.
    task automatic build_frame(input logic [49:0] v);
        logic dir = v[49];
        logic [2:0] echo = v[48:46];
        logic [45:0] pay = v[45:0];
        logic neg_next = 1'b1;
        logic par = 1'b0;
        logic b;
        exp_frame[0] = 2'b01;
        exp_frame[1] = 2'b10;
        for (int p = 2; p < FLEN; p++) begin
            logic is_bal;
            is_bal = dir ? (p == 47) : (p % 12 == 11);
            if (dir && (p == 12 || p == 24 || p == 36)) b = echo[p / 12 - 1];
            else if (is_bal) b = ~par;
            else b = pay[p - 2];
            if (is_bal) par = 1'b0;
            else if (!b) par = ~par;
            if (b) begin
                exp_frame[p] = 2'b00;
            end else begin
                exp_frame[p] = neg_next ? 2'b10 : 2'b01;
                neg_next = ~neg_next;
            end
        end
    endtask

    // One strobe; the output is sampled at the next falling edge.
    task automatic step();
        @(negedge clk) bit_stb = 1'b1;
        @(negedge clk) bit_stb = 1'b0;
    endtask

    task automatic run_frame(input logic [49:0] v, input int stop_at);
        build_frame(v);
        payload = v[45:0];
        nt_dir  = v[49];
        for (int p = 0; p < stop_at; p++) begin
            if (v[49] && (p == 12 || p == 24 || p == 36)) echo_bit = v[46 + p / 12 - 1];
            else echo_bit = p[0];
            step();
            if (p == 0) begin
                payload = ~v[45:0];
                nt_dir  = ~v[49];
            end
            chk(tag_of(v[49], p), line_sym, exp_frame[p]);
            if (p == 0 && stop_at == FLEN) chk("R10 frame restart", line_sym, 2'b01);
            if (p == 5) begin
                logic [1:0] held = line_sym;
                repeat (3) @(negedge clk);
                chk("R2 hold without strobe", line_sym, held);
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: line_sym=%b expected completion", line_sym);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset symbol", line_sym, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", line_sym, 2'b00);

        // Table-driven frames, back to back.
        for (int i = 0; i < NVEC; i++) begin
            run_frame(VEC[i], FLEN);
        end

        // Reset in mid-frame, then a full frame from position 0.
        run_frame(VEC[3], 20);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-frame reset", line_sym, 2'b00);
        rst_n = 1'b1;
        run_frame(VEC[2], FLEN);

        // Echo bits inverted versus the table, network side.
        run_frame({1'b1, 3'b010, 46'h1234_5678_9ABC}, FLEN);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule